// File: doc/BRIEF.md
# Reorder Buffer Retirement and Cancellation

This block tracks dispatched instructions in program order in a circular buffer and retires them from the oldest end once execution has finished. Dispatch allocates one entry per cycle at the tail. Each entry records whether the instruction has an architectural destination, the destination register number and the rename-slot tag that holds its result. Execution units report finish status by buffer index. The report carries an exception flag and a mispredicted-branch flag, and the units do not stall when they raise either one.

Up to `RET_W` finished entries leave the head each cycle, strictly in order. Each retiring result with a destination is written to the architectural register file through a single write port. The write copies the rename slot named by the tag into the named register. If the port is not ready, or an older queued result is ahead of it, the result waits in a small writeback queue and drains in a later cycle. Retirement stalls when the queue cannot take every result that would retire.

A retiring entry that carries exception or mispredict status raises a one-cycle flush. The flush names the entry as the redirect point and gives the cause. All younger entries are cancelled and their rename results are discarded. The block does not compute the fetch redirect target.

Top module: `rob_retire_unit`

## Requirements
- R1: After reset the buffer is empty: `full_o` is 0, `alloc_ready_o` is 1, `alloc_idx_o` is 0, and `retire_valid_o`, `wr_valid_o` and `flush_o` are all 0.
- R2: A dispatch is accepted on a clock edge where `alloc_valid_i` and `alloc_ready_o` are both 1. It takes the index shown on `alloc_idx_o`. Indices are handed out 0, 1, 2 and so on, wrapping modulo `DEPTH`.
- R3: `full_o` is 1 exactly when `DEPTH` entries are held. While it is 1, `alloc_ready_o` is 0 and `alloc_valid_i` has no effect: the next index handed out after the buffer drains follows on from the last accepted one.
- R4: Retirement is in order from the head, up to `RET_W` entries per cycle, and stops at the first entry that has not finished. Lane 0 of `retire_valid_o` / `retire_idx_o` (bits [IDX_W-1:0]) is the oldest entry. An entry can retire no earlier than the cycle after its finish report is sampled.
- R5: An entry that retires with a destination and without exception status produces a write on `wr_valid_o` / `wr_arch_o` / `wr_tag_o` in the same cycle, provided the writeback queue is empty and `wb_ready_i` is 1.
- R6: A result that cannot be written at once is queued. Queued results leave one per cycle in which `wb_ready_i` is 1, in retirement order, ahead of any newer result. `wr_valid_o` is never 1 while `wb_ready_i` is 0.
- R7: A cycle retires only as many destination-writing entries as fit in (`WBQ_DEPTH` − queued results + `wb_ready_i`). The first entry that does not fit, and every entry younger than it, stays in the buffer.
- R8: When an entry with exception or mispredict status retires, `flush_o` is 1 in that cycle and `redirect_idx_o` equals that entry's index. No younger lane retires in that cycle. The buffer is empty in the following cycle, and the next index handed out is the flagged index + 1.
- R9: `redirect_exc_o` is 1 for an exception and 0 for a mispredict. An exception entry makes no architectural write. A mispredicted branch with a destination is written like any other result.
- R10: No dispatch is accepted in a cycle where `flush_o` is 1: `alloc_ready_o` is 0 there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alloc_valid_i | input | 1 | Dispatch request |
| alloc_has_dest_i | input | 1 | Dispatched instruction writes a register |
| alloc_arch_i | input | ARCH_W | Architectural destination register |
| alloc_tag_i | input | TAG_W | Rename slot holding the result |
| alloc_ready_o | output | 1 | Dispatch can be accepted this cycle |
| alloc_idx_o | output | IDX_W | Buffer index given to this dispatch |
| full_o | output | 1 | All entries held |
| fin_valid_i | input | 1 | Execution finish report |
| fin_idx_i | input | IDX_W | Index of the finished entry |
| fin_exc_i | input | 1 | Finished with exception status |
| fin_mispred_i | input | 1 | Finished as a mispredicted branch |
| wb_ready_i | input | 1 | Architectural write port free this cycle |
| retire_valid_o | output | RET_W | Per-lane retire strobe, lane 0 oldest |
| retire_idx_o | output | RET_W*IDX_W | Per-lane retired index |
| wr_valid_o | output | 1 | Architectural write strobe |
| wr_arch_o | output | ARCH_W | Register written |
| wr_tag_o | output | TAG_W | Rename slot copied into it |
| flush_o | output | 1 | Cancel all younger entries this cycle |
| redirect_idx_o | output | IDX_W | Index of the entry that caused the flush |
| redirect_exc_o | output | 1 | Flush cause: 1 exception, 0 mispredict |

## Verification
The bench builds the block with `DEPTH=4`, `RET_W=2`, `WBQ_DEPTH=2`, `ARCH_W=3` and `TAG_W=4`. Four entries make full, index wraparound and reuse of cancelled slots reachable within a few dozen cycles. A two-deep queue fills after two retirements with the port held busy, so the capacity limit on retirement shows up as a visible stall. Two lanes expose both flag placements: a flagged oldest entry with a finished younger one behind it, and a flagged second lane retiring together with a normal oldest entry.

// File: rtl/rob_pkg.sv
package rob_pkg;
  typedef enum logic {
    CAUSE_BRANCH    = 1'b0,
    CAUSE_EXCEPTION = 1'b1
  } redirect_cause_e;
endpackage

// File: rtl/rob_entry_store.sv
module rob_entry_store #(
  parameter int DEPTH  = 16,
  parameter int RET_W  = 2,
  parameter int ARCH_W = 5,
  parameter int TAG_W  = 6,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           alloc_we_i,
  input  logic [IDX_W-1:0]               alloc_ptr_i,
  input  logic                           alloc_has_dest_i,
  input  logic [ARCH_W-1:0]              alloc_arch_i,
  input  logic [TAG_W-1:0]               alloc_tag_i,
  input  logic                           fin_valid_i,
  input  logic [IDX_W-1:0]               fin_idx_i,
  input  logic                           fin_exc_i,
  input  logic                           fin_mispred_i,
  input  logic [IDX_W-1:0]               head_i,
  input  logic [RET_W-1:0]               ret_mask_i,
  input  logic                           flush_i,
  output logic [RET_W-1:0]               lane_done_o,
  output logic [RET_W-1:0]               lane_exc_o,
  output logic [RET_W-1:0]               lane_mis_o,
  output logic [RET_W-1:0]               lane_dest_o,
  output logic [RET_W-1:0][ARCH_W-1:0]   lane_arch_o,
  output logic [RET_W-1:0][TAG_W-1:0]    lane_tag_o
);
  logic [DEPTH-1:0] valid_q, done_q, exc_q, mis_q, dest_q;
  logic [ARCH_W-1:0] arch_q [DEPTH];
  logic [TAG_W-1:0]  tag_q  [DEPTH];
  logic [RET_W-1:0][IDX_W-1:0] lane_ptr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      done_q  <= '0;
      exc_q   <= '0;
      mis_q   <= '0;
      dest_q  <= '0;
    end else begin
      if (fin_valid_i && valid_q[fin_idx_i]) begin
        done_q[fin_idx_i] <= 1'b1;
        exc_q[fin_idx_i]  <= fin_exc_i;
        mis_q[fin_idx_i]  <= fin_mispred_i;
      end
      for (int l = 0; l < RET_W; l++)
        if (ret_mask_i[l]) valid_q[lane_ptr[l]] <= 1'b0;
      if (flush_i) valid_q <= '0;
      if (alloc_we_i) begin
        valid_q[alloc_ptr_i] <= 1'b1;
        done_q[alloc_ptr_i]  <= 1'b0;
        exc_q[alloc_ptr_i]   <= 1'b0;
        mis_q[alloc_ptr_i]   <= 1'b0;
        dest_q[alloc_ptr_i]  <= alloc_has_dest_i;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (alloc_we_i) begin
      arch_q[alloc_ptr_i] <= alloc_arch_i;
      tag_q[alloc_ptr_i]  <= alloc_tag_i;
    end
  end

  always_comb begin
    for (int l = 0; l < RET_W; l++) begin
      lane_ptr[l]    = head_i + IDX_W'(l);
      lane_done_o[l] = valid_q[lane_ptr[l]] && done_q[lane_ptr[l]];
      lane_exc_o[l]  = exc_q[lane_ptr[l]];
      lane_mis_o[l]  = mis_q[lane_ptr[l]];
      lane_dest_o[l] = dest_q[lane_ptr[l]];
      lane_arch_o[l] = arch_q[lane_ptr[l]];
      lane_tag_o[l]  = tag_q[lane_ptr[l]];
    end
  end
endmodule

// File: rtl/rob_retire_pick.sv
module rob_retire_pick
  import rob_pkg::*;
#(
  parameter int RET_W = 2,
  parameter int CAP_W = 3,
  localparam int LANE_W = (RET_W > 1) ? $clog2(RET_W) : 1
) (
  input  logic [RET_W-1:0]  lane_done_i,
  input  logic [RET_W-1:0]  lane_exc_i,
  input  logic [RET_W-1:0]  lane_mis_i,
  input  logic [RET_W-1:0]  lane_dest_i,
  input  logic [CAP_W-1:0]  cap_i,
  output logic [RET_W-1:0]  ret_o,
  output logic [RET_W-1:0]  commit_o,
  output logic              flush_o,
  output logic [LANE_W-1:0] flush_lane_o,
  output redirect_cause_e   cause_o
);
  logic             stop;
  logic [CAP_W-1:0] used;
  logic             needs;

  always_comb begin
    ret_o        = '0;
    commit_o     = '0;
    flush_o      = 1'b0;
    flush_lane_o = '0;
    cause_o      = CAUSE_BRANCH;
    stop         = 1'b0;
    used         = '0;
    needs        = 1'b0;
    for (int l = 0; l < RET_W; l++) begin
      needs = lane_dest_i[l] && !lane_exc_i[l];
      if (!stop && lane_done_i[l] && (!needs || used < cap_i)) begin
        ret_o[l]    = 1'b1;
        commit_o[l] = needs;
        if (needs) used = used + CAP_W'(1);
        if (lane_exc_i[l] || lane_mis_i[l]) begin
          flush_o      = 1'b1;
          flush_lane_o = LANE_W'(l);
          cause_o      = lane_exc_i[l] ? CAUSE_EXCEPTION : CAUSE_BRANCH;
          stop         = 1'b1;
        end
      end else begin
        stop = 1'b1;
      end
    end
  end
endmodule

// File: rtl/rob_wb_queue.sv
module rob_wb_queue #(
  parameter int DEPTH  = 4,
  parameter int RET_W  = 2,
  parameter int ARCH_W = 5,
  parameter int TAG_W  = 6,
  localparam int QI_W  = $clog2(DEPTH),
  localparam int QC_W  = QI_W + 1
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         ready_i,
  input  logic [RET_W-1:0]             push_i,
  input  logic [RET_W-1:0][ARCH_W-1:0] push_arch_i,
  input  logic [RET_W-1:0][TAG_W-1:0]  push_tag_i,
  output logic [QC_W-1:0]              cap_o,
  output logic                         wr_valid_o,
  output logic [ARCH_W-1:0]            wr_arch_o,
  output logic [TAG_W-1:0]             wr_tag_o
);
  localparam logic [QC_W-1:0] DEPTH_C = QC_W'(DEPTH);

  logic [ARCH_W-1:0] arch_q [DEPTH];
  logic [TAG_W-1:0]  tag_q  [DEPTH];
  logic [QI_W-1:0]   rd_q, wr_q;
  logic [QC_W-1:0]   cnt_q, k;
  logic [RET_W-1:0]  en;
  logic [RET_W-1:0][QI_W-1:0] slot;
  logic              direct, taken, pop;
  int                first;

  assign cap_o  = DEPTH_C - cnt_q + QC_W'(ready_i);
  assign direct = ready_i && (cnt_q == '0);
  assign pop    = ready_i && (cnt_q != '0);

  always_comb begin
    first = 0;
    for (int l = RET_W - 1; l >= 0; l--)
      if (push_i[l]) first = l;
    wr_valid_o = pop || (direct && |push_i);
    wr_arch_o  = pop ? arch_q[rd_q] : push_arch_i[first];
    wr_tag_o   = pop ? tag_q[rd_q]  : push_tag_i[first];
  end

  // oldest retiring result bypasses an empty queue; the rest are appended
  always_comb begin
    k     = '0;
    taken = 1'b0;
    en    = '0;
    slot  = '0;
    for (int l = 0; l < RET_W; l++) begin
      if (push_i[l]) begin
        if (direct && !taken) begin
          taken = 1'b1;
        end else begin
          en[l]   = 1'b1;
          slot[l] = wr_q + QI_W'(k);
          k       = k + QC_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_q + QI_W'(k);
      if (pop) rd_q <= rd_q + QI_W'(1);
      cnt_q <= cnt_q + k - QC_W'(pop);
    end
  end

  always_ff @(posedge clk_i) begin
    for (int l = 0; l < RET_W; l++)
      if (en[l]) begin
        arch_q[slot[l]] <= push_arch_i[l];
        tag_q[slot[l]]  <= push_tag_i[l];
      end
  end

  AST_WBQ_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= DEPTH_C); // R7
  AST_WR_NEEDS_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> ready_i); // R6
endmodule

// File: rtl/rob_retire_unit.sv
module rob_retire_unit
  import rob_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int RET_W     = 2,
  parameter int WBQ_DEPTH = 4,
  parameter int ARCH_W    = 5,
  parameter int TAG_W     = 6,
  localparam int IDX_W    = $clog2(DEPTH),
  localparam int CNT_W    = IDX_W + 1,
  localparam int CAP_W    = $clog2(WBQ_DEPTH) + 1,
  localparam int LANE_W   = (RET_W > 1) ? $clog2(RET_W) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   alloc_valid_i,
  input  logic                   alloc_has_dest_i,
  input  logic [ARCH_W-1:0]      alloc_arch_i,
  input  logic [TAG_W-1:0]       alloc_tag_i,
  output logic                   alloc_ready_o,
  output logic [IDX_W-1:0]       alloc_idx_o,
  output logic                   full_o,
  input  logic                   fin_valid_i,
  input  logic [IDX_W-1:0]       fin_idx_i,
  input  logic                   fin_exc_i,
  input  logic                   fin_mispred_i,
  input  logic                   wb_ready_i,
  output logic [RET_W-1:0]       retire_valid_o,
  output logic [RET_W*IDX_W-1:0] retire_idx_o,
  output logic                   wr_valid_o,
  output logic [ARCH_W-1:0]      wr_arch_o,
  output logic [TAG_W-1:0]       wr_tag_o,
  output logic                   flush_o,
  output logic [IDX_W-1:0]       redirect_idx_o,
  output logic                   redirect_exc_o
);
  logic [IDX_W-1:0] head_q, tail_q;
  logic [CNT_W-1:0] count_q, n_ret;
  logic             alloc_fire;

  logic [RET_W-1:0]             lane_done, lane_exc, lane_mis, lane_dest, ret, commit;
  logic [RET_W-1:0][ARCH_W-1:0] lane_arch;
  logic [RET_W-1:0][TAG_W-1:0]  lane_tag;
  logic [CAP_W-1:0]             cap;
  logic [LANE_W-1:0]            flush_lane;
  redirect_cause_e              cause;

  assign full_o         = (count_q == CNT_W'(DEPTH));
  assign alloc_ready_o  = !full_o && !flush_o;
  assign alloc_fire     = alloc_valid_i && alloc_ready_o;
  assign alloc_idx_o    = tail_q;
  assign retire_valid_o = ret;
  assign redirect_idx_o = head_q + IDX_W'(flush_lane);
  assign redirect_exc_o = (cause == CAUSE_EXCEPTION);

  always_comb begin
    n_ret = '0;
    for (int l = 0; l < RET_W; l++) begin
      n_ret = n_ret + CNT_W'(ret[l]);
      retire_idx_o[l*IDX_W +: IDX_W] = head_q + IDX_W'(l);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else begin
      head_q <= head_q + IDX_W'(n_ret);
      if (flush_o) begin
        tail_q  <= head_q + IDX_W'(n_ret);
        count_q <= '0;
      end else begin
        tail_q  <= tail_q + IDX_W'(alloc_fire);
        count_q <= count_q - n_ret + CNT_W'(alloc_fire);
      end
    end
  end

  rob_entry_store #(.DEPTH(DEPTH), .RET_W(RET_W), .ARCH_W(ARCH_W), .TAG_W(TAG_W)) u_store (
    .clk_i, .rst_ni,
    .alloc_we_i(alloc_fire), .alloc_ptr_i(tail_q),
    .alloc_has_dest_i, .alloc_arch_i, .alloc_tag_i,
    .fin_valid_i, .fin_idx_i, .fin_exc_i, .fin_mispred_i,
    .head_i(head_q), .ret_mask_i(ret), .flush_i(flush_o),
    .lane_done_o(lane_done), .lane_exc_o(lane_exc), .lane_mis_o(lane_mis),
    .lane_dest_o(lane_dest), .lane_arch_o(lane_arch), .lane_tag_o(lane_tag)
  );

  rob_retire_pick #(.RET_W(RET_W), .CAP_W(CAP_W)) u_pick (
    .lane_done_i(lane_done), .lane_exc_i(lane_exc), .lane_mis_i(lane_mis),
    .lane_dest_i(lane_dest), .cap_i(cap),
    .ret_o(ret), .commit_o(commit), .flush_o(flush_o),
    .flush_lane_o(flush_lane), .cause_o(cause)
  );

  rob_wb_queue #(.DEPTH(WBQ_DEPTH), .RET_W(RET_W), .ARCH_W(ARCH_W), .TAG_W(TAG_W)) u_wbq (
    .clk_i, .rst_ni, .ready_i(wb_ready_i),
    .push_i(commit), .push_arch_i(lane_arch), .push_tag_i(lane_tag),
    .cap_o(cap), .wr_valid_o, .wr_arch_o, .wr_tag_o
  );

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CNT_W'(DEPTH)); // R3
  AST_FLUSH_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |=> (count_q == '0)); // R8

  generate
    for (genvar g = 1; g < RET_W; g++) begin : g_contig
      AST_RETIRE_IN_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
        retire_valid_o[g] |-> retire_valid_o[g-1]); // R4
    end
  endgenerate
endmodule

// File: tb/rob_retire_unit_test.sv
module rob_retire_unit_test;
  localparam int DEPTH = 4, RET_W = 2, WBQ = 2, ARCH_W = 3, TAG_W = 4;
  localparam int IDX_W = $clog2(DEPTH);

  logic clk = 1'b0, rst_ni = 1'b0;
  logic alloc_valid_i = 0, alloc_has_dest_i = 0;
  logic [ARCH_W-1:0] alloc_arch_i = '0;
  logic [TAG_W-1:0]  alloc_tag_i = '0;
  logic alloc_ready_o, full_o;
  logic [IDX_W-1:0] alloc_idx_o;
  logic fin_valid_i = 0, fin_exc_i = 0, fin_mispred_i = 0;
  logic [IDX_W-1:0] fin_idx_i = '0;
  logic wb_ready_i = 1'b1;
  logic [RET_W-1:0] retire_valid_o;
  logic [RET_W*IDX_W-1:0] retire_idx_o;
  logic wr_valid_o;
  logic [ARCH_W-1:0] wr_arch_o;
  logic [TAG_W-1:0] wr_tag_o;
  logic flush_o, redirect_exc_o;
  logic [IDX_W-1:0] redirect_idx_o;

  int n_checks = 0, n_fail = 0;

  always #10 clk = ~clk;

  rob_retire_unit #(.DEPTH(DEPTH), .RET_W(RET_W), .WBQ_DEPTH(WBQ),
                    .ARCH_W(ARCH_W), .TAG_W(TAG_W)) uut (
    .clk_i(clk), .rst_ni, .alloc_valid_i, .alloc_has_dest_i, .alloc_arch_i,
    .alloc_tag_i, .alloc_ready_o, .alloc_idx_o, .full_o, .fin_valid_i,
    .fin_idx_i, .fin_exc_i, .fin_mispred_i, .wb_ready_i, .retire_valid_o,
    .retire_idx_o, .wr_valid_o, .wr_arch_o, .wr_tag_o, .flush_o,
    .redirect_idx_o, .redirect_exc_o
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #4;
  endtask

  task automatic fin(input int idx, input bit exc, input bit mis);
    fin_valid_i = 1'b1; fin_idx_i = IDX_W'(idx); fin_exc_i = exc; fin_mispred_i = mis;
  endtask

  task automatic fin_off;
    fin_valid_i = 1'b0; fin_exc_i = 1'b0; fin_mispred_i = 1'b0;
  endtask

  task automatic chk_wr(input string req, input int v, input int arch, input int tag);
    chk(req, "wr_valid", int'(wr_valid_o), v);
    if (v != 0) begin
      chk(req, "wr_arch", int'(wr_arch_o), arch);
      chk(req, "wr_tag", int'(wr_tag_o), tag);
    end
  endtask

  task automatic chk_ret(input string req, input int mask, input int i0, input int i1);
    chk(req, "retire_valid", int'(retire_valid_o), mask);
    if (mask[0]) chk(req, "retire_idx0", int'(retire_idx_o[IDX_W-1:0]), i0);
    if (mask[1]) chk(req, "retire_idx1", int'(retire_idx_o[2*IDX_W-1:IDX_W]), i1);
  endtask

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    tick; tick;
    rst_ni = 1'b1;
    #1;
    // R1 reset state
    chk("R1", "full", int'(full_o), 0);
    chk("R1", "alloc_ready", int'(alloc_ready_o), 1);
    chk("R1", "alloc_idx", int'(alloc_idx_o), 0);
    chk("R1", "retire_valid", int'(retire_valid_o), 0);
    chk("R1", "wr_valid", int'(wr_valid_o), 0);
    chk("R1", "flush", int'(flush_o), 0);
    tick;

    // R2 allocate four: e2 has no destination
    for (int i = 0; i < 4; i++) begin
      alloc_valid_i = 1'b1; alloc_has_dest_i = (i != 2);
      alloc_arch_i = ARCH_W'(i + 1); alloc_tag_i = TAG_W'(i + 1);
      #1;
      chk("R2", "alloc_ready", int'(alloc_ready_o), 1);
      chk("R2", "alloc_idx", int'(alloc_idx_o), i);
      tick;
    end
    #1;
    // R3 full, request held anyway
    chk("R3", "full", int'(full_o), 1);
    chk("R3", "alloc_ready", int'(alloc_ready_o), 0);
    tick;
    alloc_valid_i = 1'b0;

    // R4 out-of-order finish does not retire
    fin(1, 0, 0); tick; fin_off; #1;
    chk_ret("R4", 0, 0, 0);
    fin(0, 0, 0); tick; fin_off; #1;
    chk_ret("R4", 3, 0, 1);
    chk_wr("R5", 1, 1, 1);
    tick; #1;
    chk_ret("R4", 0, 0, 0);
    chk_wr("R6", 1, 2, 2);

    // R6 port busy: results queue
    tick;
    wb_ready_i = 1'b0;
    fin(3, 0, 0); tick; fin_off; #1;
    chk_ret("R4", 0, 0, 0);
    fin(2, 0, 0); tick; fin_off; #1;
    chk_ret("R4", 3, 2, 3);
    chk_wr("R6", 0, 0, 0);
    tick; #1;
    chk("R3", "alloc_idx after wrap", int'(alloc_idx_o), 0);
    chk("R3", "full after drain", int'(full_o), 0);
    chk_wr("R6", 0, 0, 0);
    wb_ready_i = 1'b1; #1;
    chk_wr("R6", 1, 4, 4);
    tick;
    wb_ready_i = 1'b0;

    // R7 queue capacity limits retirement
    for (int i = 0; i < 4; i++) begin
      alloc_valid_i = 1'b1; alloc_has_dest_i = 1'b1;
      alloc_arch_i = ARCH_W'(i + 4); alloc_tag_i = TAG_W'(i + 8);
      #1;
      chk("R2", "alloc_idx", int'(alloc_idx_o), i);
      tick;
    end
    alloc_valid_i = 1'b0;
    fin(0, 0, 0); tick;
    fin(1, 0, 0); #1;
    chk_ret("R4", 1, 0, 0);
    tick;
    fin(2, 0, 0); #1;
    chk_ret("R7", 1, 1, 0);
    tick;
    fin(3, 0, 0); #1;
    chk_ret("R7", 0, 0, 0);
    tick;
    fin_off; #1;
    chk_ret("R7", 0, 0, 0);
    chk_wr("R6", 0, 0, 0);
    wb_ready_i = 1'b1; #1;
    chk_ret("R7", 1, 2, 0);
    chk_wr("R6", 1, 4, 8);
    tick; #1;
    chk_ret("R7", 1, 3, 0);
    chk_wr("R6", 1, 5, 9);
    tick; #1;
    chk_ret("R7", 0, 0, 0);
    chk_wr("R6", 1, 6, 10);
    tick; #1;
    chk_wr("R6", 1, 7, 11);
    tick; #1;
    chk_wr("R6", 0, 0, 0);

    // R8 mispredict in lane 1
    for (int i = 0; i < 3; i++) begin
      alloc_valid_i = 1'b1; alloc_has_dest_i = 1'b1;
      alloc_arch_i = ARCH_W'(i + 1); alloc_tag_i = TAG_W'(i + 12);
      #1;
      chk("R2", "alloc_idx", int'(alloc_idx_o), i);
      tick;
    end
    alloc_valid_i = 1'b0;
    fin(2, 0, 0); tick;
    fin(1, 0, 1); tick;
    fin(0, 0, 0); tick;
    fin_off;
    alloc_valid_i = 1'b1; alloc_has_dest_i = 1'b1; alloc_arch_i = 3'd5; alloc_tag_i = 4'd15;
    #1;
    chk_ret("R8", 3, 0, 1);
    chk("R8", "flush", int'(flush_o), 1);
    chk("R8", "redirect_idx", int'(redirect_idx_o), 1);
    chk("R9", "redirect_exc", int'(redirect_exc_o), 0);
    chk_wr("R5", 1, 1, 12);
    chk("R10", "alloc_ready in flush", int'(alloc_ready_o), 0);
    tick;
    alloc_valid_i = 1'b0; #1;
    chk("R8", "flush pulse", int'(flush_o), 0);
    chk_wr("R9", 1, 2, 13);
    chk_ret("R8", 0, 0, 0);
    chk("R8", "alloc_idx after flush", int'(alloc_idx_o), 2);
    tick; #1;
    chk_ret("R8", 0, 0, 0);
    chk_wr("R8", 0, 0, 0);

    // R9 exception in lane 0, younger finished entry behind it
    alloc_valid_i = 1'b1; alloc_arch_i = 3'd5; alloc_tag_i = 4'd15; #1;
    chk("R8", "reused idx", int'(alloc_idx_o), 2);
    tick;
    alloc_arch_i = 3'd6; alloc_tag_i = 4'd3; #1;
    chk("R2", "alloc_idx", int'(alloc_idx_o), 3);
    tick;
    alloc_valid_i = 1'b0;
    fin(3, 0, 0); tick;
    fin(2, 1, 0); tick;
    fin_off; #1;
    chk_ret("R8", 1, 2, 0);
    chk("R8", "flush", int'(flush_o), 1);
    chk("R8", "redirect_idx", int'(redirect_idx_o), 2);
    chk("R9", "redirect_exc", int'(redirect_exc_o), 1);
    chk_wr("R9", 0, 0, 0);
    tick; #1;
    chk_ret("R8", 0, 0, 0);
    chk("R8", "flush pulse", int'(flush_o), 0);
    chk("R8", "alloc_idx after flush", int'(alloc_idx_o), 3);
    chk("R8", "empty", int'(full_o), 0);

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule